// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block is a bank of bidirectional bus channels, by default 36 bits wide and divided into two halves of 18 channels. Each half has its own control set for each direction. Data moving from the A side to the B side, or from B to A, passes through one storage element per channel. That element runs in one of three modes. It is transparent while its pass-through control is high. It holds its contents while that control is low and the strobe stays at one level. It captures new data when the strobe goes from low to high while the pass-through control is low.

The destination side of each direction has an output enable. The A-to-B enable is active high and the B-to-A enable is active low. The block does not use internal tri-states. Each port appears as an input vector, a resolved output vector and a per-half flag that says whether the block drives that port. When a port is released, a keeper holds the value the block last drove, which models bus-hold. The strobes are ordinary level inputs. A free-running system clock samples them and looks for rising edges, so the block is a plain synchronous design.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: Each half (channels h*18 to h*18+17) responds only to its own six control bits. Activity on one half never changes the other half's outputs or stored data.
- R2: While a direction's pass-through control is 1, its destination output follows the source input in the same cycle, with no clock edge needed. The storage also loads the source value on every system clock edge.
- R3: While the pass-through control is 0 and the sampled strobe shows no low-to-high change, the stored value and the driven output stay unchanged, whatever the source input does.
- R4: While the pass-through control is 0, a strobe level of 1 sampled at a system clock edge, after a 0 at the previous edge, captures the source input present at that edge. The output shows the new value from the following cycle.
- R5: If the pass-through control falls while the strobe is high, the output holds the source value sampled at the last system clock edge before the fall.
- R6: The A-to-B enable is active high. When it is 0, the B drive flag of that half is 0 and the half's B output shows the keeper value.
- R7: The B-to-A enable is active low and acts on the A port in the same way. Apart from that, B-to-A data flow mirrors A-to-B with its own pass-through control and strobe.
- R8: The keeper of a port loads the driven value at each system clock edge while the port is enabled. While the port is released, the keeper holds, and the port output shows the held value.
- R9: An active-low asynchronous reset sets every storage element and every keeper to zero.
- R10: The strobe sampler resets to level 1. A strobe held high through reset release therefore causes no capture until it has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples strobes and updates state |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_drive_en | input | 2 | A-to-B output enable per half, active high |
| ab_transp | input | 2 | A-to-B pass-through control per half |
| ab_strobe | input | 2 | A-to-B capture strobe per half |
| ba_drive_n | input | 2 | B-to-A output enable per half, active low |
| ba_transp | input | 2 | B-to-A pass-through control per half |
| ba_strobe | input | 2 | B-to-A capture strobe per half |
| a_in | input | 36 | Level present on the A bus |
| b_in | input | 36 | Level present on the B bus |
| a_out | output | 36 | Resolved A-port value (driven or kept) |
| a_oe | output | 2 | Per-half flag, block drives the A port |
| b_out | output | 36 | Resolved B-port value (driven or kept) |
| b_oe | output | 2 | Per-half flag, block drives the B port |

## Verification
Two events can fall on the same clock edge. The first is a strobe rising edge in the same cycle the pass-through control drops. The second is an output release on the edge where the storage captures new data. In that case the keeper must hold the value driven before the edge, not the newly captured one. Directed sequences set up both collisions for each direction, and a long random phase produces them at random. A behavioural reference model of the mode table tracks storage, strobe history and keeper per half and per direction. The bench compares every output against that model once per cycle, after the inputs have settled.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Storage modes, for reading waveforms and for documentation
   typedef enum logic [1:0] {
      MODE_HOLD    = 2'd0,
      MODE_CAPTURE = 2'd1,
      MODE_PASS    = 2'd2
   } store_mode_t;

   // Controls of one direction of one half
   typedef struct packed {
      logic transp;
      logic strobe;
      logic drive;
   } dir_ctrl_t;

   function automatic store_mode_t decode_mode(input logic transp, input logic rise);
      if (transp)    return MODE_PASS;
      else if (rise) return MODE_CAPTURE;
      else           return MODE_HOLD;
   endfunction

endpackage

// File: rtl/xcvr_dir_store.sv
module xcvr_dir_store
   import xcvr_pkg::*;
#(
   parameter int unsigned W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         transp,
   input  logic         strobe,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] st;
   logic         strobe_q;
   logic         rise;
   store_mode_t  mode;

   assign rise = strobe & ~strobe_q;
   assign mode = decode_mode(transp, rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= '0;
         strobe_q <= 1'b1;
      end else begin
         strobe_q <= strobe;
         if (mode != MODE_HOLD) st <= d;
      end
   end

   // pass-through bypasses the storage combinationally
   assign q = transp ? d : st;

   a_r2_track_while_open: assert property (@(posedge clk) disable iff (!rst_n)
      transp |=> st == $past(d));

   a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!transp && !(strobe && !strobe_q)) |=> $stable(st));

   a_r4_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!transp && strobe && !strobe_q) |=> st == $past(d));

endmodule

// File: rtl/xcvr_port_keeper.sv
module xcvr_port_keeper #(
   parameter int unsigned W    = 18,
   parameter bit          KEEP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] drv,
   output logic [W-1:0] line
);

   generate
      if (KEEP) begin : g_keep
         logic [W-1:0] hold;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  hold <= '0;
            else if (en) hold <= drv;
         end

         assign line = en ? drv : hold;

         a_r8_hold_loads: assert property (@(posedge clk) disable iff (!rst_n)
            en |=> hold == $past(drv));

         a_r8_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> $stable(hold));

         a_r6_released_steady: assert property (@(posedge clk) disable iff (!rst_n)
            (!en && $past(!en)) |-> $stable(line));
      end else begin : g_nokeep
         // a released port without a keeper reads as zero
         assign line = en ? drv : '0;
      end
   endgenerate

endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr #(
   parameter int unsigned WIDTH  = 36,
   parameter int unsigned NHALF  = 2,
   parameter bit          KEEPER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NHALF-1:0] ab_drive_en,
   input  logic [NHALF-1:0] ab_transp,
   input  logic [NHALF-1:0] ab_strobe,
   input  logic [NHALF-1:0] ba_drive_n,
   input  logic [NHALF-1:0] ba_transp,
   input  logic [NHALF-1:0] ba_strobe,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_out,
   output logic [NHALF-1:0] a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic [NHALF-1:0] b_oe
);
   import xcvr_pkg::*;

   localparam int unsigned HW = WIDTH / NHALF;

   generate
      if (NHALF < 1) begin : g_bad_nhalf
         $error("NHALF must be at least 1");
      end
      if (WIDTH % NHALF != 0) begin : g_bad_split
         $error("WIDTH must divide evenly into NHALF groups");
      end
   endgenerate

   genvar h;
   generate
      for (h = 0; h < NHALF; h++) begin : g_half
         dir_ctrl_t    c_ab, c_ba;
         logic [HW-1:0] q_ab, q_ba;

         assign c_ab = '{transp: ab_transp[h], strobe: ab_strobe[h], drive: ab_drive_en[h]};
         assign c_ba = '{transp: ba_transp[h], strobe: ba_strobe[h], drive: ~ba_drive_n[h]};

         xcvr_dir_store #(.W(HW)) u_st_ab (
            .clk    (clk),
            .rst_n  (rst_n),
            .transp (c_ab.transp),
            .strobe (c_ab.strobe),
            .d      (a_in[h*HW +: HW]),
            .q      (q_ab)
         );

         xcvr_dir_store #(.W(HW)) u_st_ba (
            .clk    (clk),
            .rst_n  (rst_n),
            .transp (c_ba.transp),
            .strobe (c_ba.strobe),
            .d      (b_in[h*HW +: HW]),
            .q      (q_ba)
         );

         xcvr_port_keeper #(.W(HW), .KEEP(KEEPER)) u_keep_b (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (c_ab.drive),
            .drv   (q_ab),
            .line  (b_out[h*HW +: HW])
         );

         xcvr_port_keeper #(.W(HW), .KEEP(KEEPER)) u_keep_a (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (c_ba.drive),
            .drv   (q_ba),
            .line  (a_out[h*HW +: HW])
         );

         assign b_oe[h] = c_ab.drive;
         assign a_oe[h] = c_ba.drive;
      end
   endgenerate

endmodule

// File: tb/bidir_latch_xcvr_bench.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ab_drive_en = '0, ab_transp = '0, ab_strobe = '0;
   logic [1:0]  ba_drive_n = '1, ba_transp = '0, ba_strobe = '0;
   logic [35:0] a_in = '0, b_in = '0;
   logic [35:0] a_out, b_out;
   logic [1:0]  a_oe, b_oe;

   int checks = 0;
   int errors = 0;

   // reference state: [half][dir], dir 0 = A to B, 1 = B to A
   logic [17:0] m_st   [2][2];
   logic        m_pclk [2][2];
   logic [17:0] m_keep [2][2];

   always #4 clk = ~clk;

   bidir_latch_xcvr u_bidir_latch_xcvr (
      .clk(clk), .rst_n(rst_n),
      .ab_drive_en(ab_drive_en), .ab_transp(ab_transp), .ab_strobe(ab_strobe),
      .ba_drive_n(ba_drive_n), .ba_transp(ba_transp), .ba_strobe(ba_strobe),
      .a_in(a_in), .b_in(b_in),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   function automatic logic [17:0] m_q(input int h, input int dr);
      logic le;
      logic [17:0] d;
      le = dr == 0 ? ab_transp[h] : ba_transp[h];
      d  = dr == 0 ? a_in[h*18 +: 18] : b_in[h*18 +: 18];
      return le ? d : m_st[h][dr];
   endfunction

   function automatic logic m_en(input int h, input int dr);
      return dr == 0 ? ab_drive_en[h] : ~ba_drive_n[h];
   endfunction

   task automatic m_reset();
      for (int h = 0; h < 2; h++)
         for (int dr = 0; dr < 2; dr++) begin
            m_st[h][dr] = '0; m_pclk[h][dr] = 1'b1; m_keep[h][dr] = '0;
         end
   endtask

   task automatic m_edge();
      for (int h = 0; h < 2; h++)
         for (int dr = 0; dr < 2; dr++) begin
            logic le, ck;
            logic [17:0] d, q;
            le = dr == 0 ? ab_transp[h] : ba_transp[h];
            ck = dr == 0 ? ab_strobe[h] : ba_strobe[h];
            d  = dr == 0 ? a_in[h*18 +: 18] : b_in[h*18 +: 18];
            q  = m_q(h, dr);
            if (m_en(h, dr)) m_keep[h][dr] = q;
            if (le || (ck && !m_pclk[h][dr])) m_st[h][dr] = d;
            m_pclk[h][dr] = ck;
         end
   endtask

   task automatic check(input string tag);
      logic [35:0] ea, eb;
      logic [1:0]  eao, ebo;
      for (int h = 0; h < 2; h++) begin
         ebo[h] = m_en(h, 0);
         eao[h] = m_en(h, 1);
         eb[h*18 +: 18] = ebo[h] ? m_q(h, 0) : m_keep[h][0];
         ea[h*18 +: 18] = eao[h] ? m_q(h, 1) : m_keep[h][1];
      end
      checks++;
      if (b_out !== eb) begin errors++; $display("FAIL %s b_out got %h exp %h", tag, b_out, eb); end
      checks++;
      if (a_out !== ea) begin errors++; $display("FAIL %s a_out got %h exp %h", tag, a_out, ea); end
      checks++;
      if ({a_oe, b_oe} !== {eao, ebo}) begin
         errors++; $display("FAIL %s oe got %b exp %b", tag, {a_oe, b_oe}, {eao, ebo});
      end
   endtask

   // inputs were changed at a falling edge; settle, compare, then advance one clock
   task automatic cyc(input string tag);
      #1 check(tag);
      @(posedge clk);
      if (rst_n) m_edge();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      m_reset();
      @(negedge clk);
      // R9: reset clears storage and keepers, drive flags still follow enables
      ab_drive_en = 2'b11; ba_drive_n = 2'b00; a_in = '1; b_in = '1;
      ab_strobe = 2'b11; ba_strobe = 2'b11;
      repeat (3) cyc("R9 reset");
      // R10: strobes held high through reset release cause no capture
      rst_n = 1'b1;
      a_in = 36'h5_A5A5_A5A5; b_in = 36'h3_C3C3_C3C3;
      repeat (3) cyc("R10 strobe high at release");
      // R2: pass-through follows the input within the cycle
      ab_transp = 2'b11; ba_transp = 2'b11;
      for (int i = 0; i < 4; i++) begin
         a_in = 36'({$urandom(), $urandom()}); b_in = 36'({$urandom(), $urandom()});
         cyc("R2 transparent");
      end
      // R5: pass-through falls while strobe high, earlier value kept
      ab_transp = 2'b00; ba_transp = 2'b00;
      a_in = 36'h1_1111_2222; b_in = 36'h2_3333_4444;
      cyc("R5 latch on fall");
      // R3: strobe steady, inputs wander, stored value held
      for (int i = 0; i < 4; i++) begin
         a_in = 36'({$urandom(), $urandom()}); b_in = 36'({$urandom(), $urandom()});
         if (i == 2) begin ab_strobe = 2'b00; ba_strobe = 2'b00; end
         cyc("R3 hold");
      end
      // R4: rising strobe captures
      a_in = 36'h9_8765_4321; b_in = 36'h0_0F0F_F0F0;
      ab_strobe = 2'b11; ba_strobe = 2'b11;
      cyc("R4 capture edge");
      a_in = '0; b_in = '0;
      cyc("R4 captured value shown");
      // collision: release outputs on a capture edge, keeper keeps pre-edge value
      ab_strobe = 2'b00; ba_strobe = 2'b00;
      cyc("R4 strobe low");
      a_in = 36'hA_BCDE_F012; b_in = 36'h7_6543_210F;
      ab_strobe = 2'b11; ba_strobe = 2'b11;
      ab_drive_en = 2'b00; ba_drive_n = 2'b11;
      cyc("R6 R7 release on capture");
      repeat (3) cyc("R8 keeper holds");
      // R8: re-enable shows the captured data
      ab_drive_en = 2'b11; ba_drive_n = 2'b00;
      cyc("R8 re-enable");
      // collision: pass-through falls on the same edge that the strobe rises
      ab_strobe = 2'b00; ba_strobe = 2'b00; ab_transp = 2'b11; ba_transp = 2'b11;
      a_in = 36'h1_2345_6789; b_in = 36'h8_8888_7777;
      cyc("R2 open again");
      ab_transp = 2'b00; ba_transp = 2'b00; ab_strobe = 2'b11; ba_strobe = 2'b11;
      a_in = 36'hF_0000_FFFF; b_in = 36'h0_FFFF_0000;
      cyc("R4 R5 fall with rise");
      cyc("R4 R5 after collision");
      // R1: only half 0 acts, half 1 must not move
      ab_strobe = 2'b00; ba_strobe = 2'b00;
      cyc("R1 setup");
      ab_transp = 2'b01; ba_strobe = 2'b01; ab_drive_en = 2'b10; ba_drive_n = 2'b01;
      for (int i = 0; i < 4; i++) begin
         a_in = 36'({$urandom(), $urandom()}); b_in = 36'({$urandom(), $urandom()});
         ba_strobe[0] = ~ba_strobe[0];
         cyc("R1 half isolation");
      end
      // random phase across all modes, both directions
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom();
         ab_drive_en = r[1:0]; ab_transp = r[3:2] & r[13:12]; ab_strobe = r[5:4];
         ba_drive_n  = r[7:6]; ba_transp = r[9:8] & r[15:14]; ba_strobe = r[11:10];
         if (r[16]) a_in = 36'({$urandom(), $urandom()});
         if (r[17]) b_in = 36'({$urandom(), $urandom()});
         if (r[27:18] == 10'd5) begin
            rst_n = 1'b0; m_reset();
            cyc("R9 random reset");
            rst_n = 1'b1;
         end
         cyc("R1 R3 R6 R7 R8 random");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule